// File: doc/BRIEF.md
# PAUSE Frame Generator with Watermark Hysteresis

This block watches the occupancy of a receive FIFO and asks the link partner to stop or resume sending. It does so by producing Ethernet MAC control PAUSE frames as a byte stream for a transmit MAC. When the occupancy reaches a programmable high mark, the block sends a frame that asks the partner to stop ("XOFF"). That frame carries a programmable pause time, counted in quanta of 512 bit-times. Once an XOFF has gone out and the occupancy falls below a separate, lower mark, the block sends a resume frame ("XON"), which carries a pause time of zero. The gap between the two marks gives hysteresis, so a fill level that hovers near one threshold does not cause a stream of frames.

Software can force a single XOFF with a one-cycle request pulse. A global enable gates all frame generation. Each frame is 60 bytes, sent most significant byte first: destination, source, type, opcode, pause time, then zero padding. The downstream MAC adds the preamble and the frame check sequence. Threshold crossings and requests that arrive while a frame is being sent are held and served after that frame ends.

Top module: `pause_gen`

## Requirements
- R1: After reset, tx_valid_o is 0 and the XOFF-sent state is clear, so a low fill level does not produce an XON.
- R2: With enable high and no XOFF outstanding, a fill count that is equal to or greater than hi_mark_i causes one XOFF frame; a fill of hi_mark_i-1 causes none.
- R3: Every frame is exactly 60 bytes with tx_last_o on byte 60 only. Bytes 1-6 are 01 80 C2 00 00 01. Bytes 7-12 are src_mac_i, bits 47:40 first. Bytes 13-14 are 88 08 and bytes 15-16 are 00 01. Bytes 17-18 are the pause time, high byte first. All remaining bytes are 00.
- R4: With an XOFF outstanding, a fill count strictly below lo_mark_i causes one XON frame whose pause time is 0; a fill equal to lo_mark_i causes none.
- R5: No XON is sent unless an XOFF has been sent since the last XON or since reset.
- R6: Once a threshold XOFF has been sent, no further threshold XOFF is sent until an XON has been sent, however long the fill stays at or above the high mark.
- R7: A one-cycle pulse on sw_xoff_i with enable high sends one XOFF frame, whatever the fill level.
- R8: While fc_en_i is low, no new frame starts, and sw_xoff_i pulses are discarded rather than held for later.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_last_o hold their values; a byte advances only on a valid-and-ready cycle.
- R10: A crossing that occurs while a frame is being sent is held. The resulting frame begins after exactly one idle cycle following the last byte handshake.
- R11: The pause time in an XOFF frame is pause_time_i as sampled in the cycle the frame starts; later changes do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fc_en_i | input | 1 | Flow-control enable |
| fill_i | input | FILL_W | Receive FIFO occupancy |
| hi_mark_i | input | FILL_W | High-water threshold (XOFF at or above) |
| lo_mark_i | input | FILL_W | Low-water threshold (XON strictly below) |
| pause_time_i | input | 16 | Pause time for XOFF frames, in 512-bit-time quanta |
| src_mac_i | input | 48 | Source MAC address, held stable while a frame is sent |
| sw_xoff_i | input | 1 | Single-cycle software XOFF request |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the block with FILL_W = 4, so the fill count spans only 0 to 15. This makes it cheap to try every pair of high and low marks with the low mark between 1 and the high mark. For each pair, the fill ramps through every value upward and then back downward. A model in the bench predicts, for each value, whether an XOFF, an XON or nothing should appear, and each captured frame is compared byte for byte against a layout built in the bench. With this small width, the exact threshold edges (hi-1 against hi, lo against lo-1), the equal-mark case and the full hysteresis band all fall within a short run. Directed sequences cover backpressure, crossings during a frame, the enable gate and the software request.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam logic [47:0] CTRL_DA    = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;
  localparam int unsigned HDR_BYTES  = 18;

  typedef struct packed {
    logic sw;  // software XOFF request
    logic hi;  // high-water crossing
    logic lo;  // low-water crossing
  } pend_t;

  function automatic logic [7:0] frame_byte(input int unsigned idx,
                                            input logic [47:0] mac,
                                            input logic [15:0] pause);
    logic [47:0] sh;
    logic [7:0]  b;
    b = 8'h00;
    if (idx < 6) begin
      sh = CTRL_DA >> (8 * (5 - idx));
      b  = sh[7:0];
    end else if (idx < 12) begin
      sh = mac >> (8 * (11 - idx));
      b  = sh[7:0];
    end else begin
      case (idx)
        12:      b = CTRL_ETYPE[15:8];
        13:      b = CTRL_ETYPE[7:0];
        14:      b = PAUSE_OPC[15:8];
        15:      b = PAUSE_OPC[7:0];
        16:      b = pause[15:8];
        17:      b = pause[7:0];
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
#(
  parameter int FILL_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] hi_i,
  input  logic [FILL_W-1:0] lo_i,
  input  logic              sw_xoff_i,
  input  logic [15:0]       pause_time_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic [15:0]       pause_o
);
  pend_t pend_q;
  logic  xoff_sent_q;
  logic  want_xoff, want_xon, start_xoff, start_xon;

  assign want_xoff  = pend_q.sw | pend_q.hi;
  assign want_xon   = pend_q.lo;
  assign start_o    = en_i & ~busy_i & (want_xoff | want_xon);
  assign start_xoff = start_o & want_xoff;
  assign start_xon  = start_o & ~want_xoff;
  assign pause_o    = start_xoff ? pause_time_i : 16'h0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      xoff_sent_q <= 1'b0;
    end else if (!en_i) begin
      pend_q <= '0;
    end else begin
      pend_q.sw <= (pend_q.sw & ~start_xoff) | sw_xoff_i;
      // clearing on start wins over re-latching in the same cycle
      if (start_xoff)                           pend_q.hi <= 1'b0;
      else if (fill_i >= hi_i && !xoff_sent_q)  pend_q.hi <= 1'b1;
      if (start_xon)                            pend_q.lo <= 1'b0;
      else if (fill_i < lo_i && xoff_sent_q)    pend_q.lo <= 1'b1;
      if (start_xoff)     xoff_sent_q <= 1'b1;
      else if (start_xon) xoff_sent_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pause_framer.sv
module pause_framer
  import pause_pkg::*;
#(
  parameter int FRAME_BYTES = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] pause_i,
  input  logic [47:0] mac_i,
  input  logic        ready_i,
  output logic        busy_o,
  output logic [7:0]  data_o,
  output logic        valid_o,
  output logic        last_o
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      pause_q;

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign last_o  = busy_q && (idx_q == LAST_IDX);
  assign data_o  = frame_byte(32'(idx_q), mac_i, pause_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      pause_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      pause_q <= pause_i;
    end else if (busy_q && ready_i) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/pause_gen.sv
module pause_gen
  import pause_pkg::*;
#(
  parameter int FILL_W      = 12,
  parameter int FRAME_BYTES = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fc_en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] hi_mark_i,
  input  logic [FILL_W-1:0] lo_mark_i,
  input  logic [15:0]       pause_time_i,
  input  logic [47:0]       src_mac_i,
  input  logic              sw_xoff_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i
);
  logic        busy, start;
  logic [15:0] start_pause;

  pause_ctrl #(.FILL_W(FILL_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (fc_en_i),
    .fill_i       (fill_i),
    .hi_i         (hi_mark_i),
    .lo_i         (lo_mark_i),
    .sw_xoff_i    (sw_xoff_i),
    .pause_time_i (pause_time_i),
    .busy_i       (busy),
    .start_o      (start),
    .pause_o      (start_pause)
  );

  pause_framer #(.FRAME_BYTES(FRAME_BYTES)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .pause_i (start_pause),
    .mac_i   (src_mac_i),
    .ready_i (tx_ready_i),
    .busy_o  (busy),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o),
    .last_o  (tx_last_o)
  );
endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk #(
  parameter int FRAME_BYTES = 60
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fc_en_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       tx_last_o,
  input logic [7:0] tx_data_o
);
  localparam int CW = $clog2(FRAME_BYTES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (tx_valid_o && tx_ready_i && tx_last_o) cnt_q <= '0;
    else if (tx_valid_o && tx_ready_i)          cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)); // R9
  AST_DEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> tx_data_o == 8'h01); // R3
  AST_LAST_AT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_last_o == (cnt_q == CW'(FRAME_BYTES - 1)))); // R3
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_en_i && !tx_valid_o |=> !tx_valid_o); // R8
  AST_GAP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o); // R10
endmodule

bind pause_gen pause_gen_chk #(.FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fc_en_i    (fc_en_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_last_o  (tx_last_o),
  .tx_data_o  (tx_data_o)
);

// File: tb/tb_pause_gen.sv
module tb_pause_gen;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic [FW-1:0] fill = '0, hi = '0, lo = '0;
  logic [15:0]   pt = 16'h1234;
  logic [47:0]   mac = 48'h02AA_BBCC_DDEE;
  logic          sw = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_last;
  logic          tx_ready = 1'b1;

  int checks = 0, errors = 0, cyc = 0;
  bit sent = 0;
  logic [7:0] exp_b [60];

  always #4 clk = ~clk;

  pause_gen #(.FILL_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fc_en_i(en), .fill_i(fill),
    .hi_mark_i(hi), .lo_mark_i(lo), .pause_time_i(pt), .src_mac_i(mac),
    .sw_xoff_i(sw), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<190000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic void build(input logic [15:0] p);
    for (int i = 0; i < 60; i++) exp_b[i] = 8'h00;
    exp_b[0] = 8'h01; exp_b[1] = 8'h80; exp_b[2] = 8'hC2;
    exp_b[3] = 8'h00; exp_b[4] = 8'h00; exp_b[5] = 8'h01;
    for (int i = 0; i < 6; i++) exp_b[6+i] = mac[47-8*i -: 8];
    exp_b[12] = 8'h88; exp_b[13] = 8'h08;
    exp_b[14] = 8'h00; exp_b[15] = 8'h01;
    exp_b[16] = p[15:8]; exp_b[17] = p[7:0];
  endfunction

  // called at a negedge with tx_valid high; returns at the negedge of the last handshake
  task automatic recv(input logic [15:0] ep, input bit stall, input string req);
    int n = 0, bad = 0;
    bit pstall = 0;
    logic [7:0] pd = 8'h00;
    build(ep);
    for (int k = 0; k < 1000; k++) begin
      tx_ready = stall ? (k % 3 != 1) : 1'b1;
      if (pstall && tx_data !== pd) bad++;
      pstall = tx_valid && !tx_ready;
      pd = tx_data;
      if (tx_valid && tx_ready) begin
        if (n < 60 && tx_data !== exp_b[n]) bad++;
        if (tx_last !== (n == 59)) bad++;
        n++;
        if (tx_last) break;
      end
      @(negedge clk);
    end
    tx_ready = 1'b1;
    chk(bad == 0 && n == 60, req, "frame content/length (bad bytes)", bad, 0);
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (tx_valid) begin got = 1; break; end
    end
  endtask

  // set fill, predict and check the response
  task automatic step(input logic [FW-1:0] f);
    int ek;
    bit got;
    string rq;
    @(negedge clk);
    fill = f;
    if (f >= hi && !sent)     begin ek = 1; rq = "R2"; end
    else if (sent && f < lo)  begin ek = 2; rq = "R4"; end
    else                      begin ek = 0; rq = sent ? "R6" : "R5"; end
    wait_valid(4, got);
    chk(got == (ek != 0), rq, "frame presence", int'(got), int'(ek != 0));
    if (got) begin
      recv((ek == 1) ? pt : 16'h0000, 1'b0, "R3");
      sent = (ek == 1) ? 1'b1 : (ek == 2) ? 1'b0 : sent;
    end
  endtask

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    chk(tx_valid === 1'b0, "R1", "valid in reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    hi = 4'd12; lo = 4'd8; fill = 4'd0;
    wait_valid(8, got);
    chk(!got, "R1", "no XON after reset with low fill", int'(got), 0);

    // sweep every mark pair
    for (int h = 1; h < 16; h++) begin
      for (int l = 1; l <= h; l++) begin
        @(negedge clk);
        hi = FW'(h); lo = FW'(l);
        pt = 16'(h * 4111 + l * 37 + 1);
        mac = {8'h02, 8'(h), 8'(l), 24'hA5C3E1};
        for (int f = 0; f < 16; f++) step(FW'(f));
        for (int f = 15; f >= 0; f--) step(FW'(f));
      end
    end

    // R10: crossings during a frame are held, one idle cycle between frames
    hi = 4'd10; lo = 4'd5; pt = 16'hBEEF;
    @(negedge clk); fill = 4'd15;
    wait_valid(4, got);
    chk(got, "R2", "XOFF for R10 sequence", int'(got), 1);
    fill = 4'd0;
    recv(pt, 1'b0, "R3");
    @(negedge clk);
    chk(tx_valid === 1'b0, "R10", "idle cycle after XOFF", int'(tx_valid), 0);
    @(negedge clk);
    chk(tx_valid === 1'b1, "R10", "held XON starts", int'(tx_valid), 1);
    fill = 4'd15;
    recv(16'h0000, 1'b0, "R10");
    @(negedge clk);
    chk(tx_valid === 1'b0, "R10", "idle cycle after XON", int'(tx_valid), 0);
    @(negedge clk);
    chk(tx_valid === 1'b1, "R10", "held XOFF starts", int'(tx_valid), 1);
    recv(pt, 1'b0, "R10");
    sent = 1;

    // R9 + R11: backpressure, pause time changed mid-frame
    step(4'd0);
    @(negedge clk); fill = 4'd15;
    wait_valid(4, got);
    chk(got, "R11", "XOFF start", int'(got), 1);
    pt = 16'h0F0F;
    recv(16'hBEEF, 1'b1, "R9");
    sent = 1;
    step(4'd0);
    pt = 16'h4321;

    // R8: disabled
    @(negedge clk); en = 1'b0; fill = 4'd15;
    wait_valid(10, got);
    chk(!got, "R8", "no frame while disabled", int'(got), 0);
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    wait_valid(10, got);
    chk(!got, "R8", "sw request while disabled", int'(got), 0);
    en = 1'b1;
    wait_valid(4, got);
    chk(got, "R8", "XOFF once enabled", int'(got), 1);
    if (got) recv(pt, 1'b0, "R3");
    sent = 1;
    wait_valid(10, got);
    chk(!got, "R8", "discarded sw request not replayed", int'(got), 0);
    step(4'd0);

    // R7: software XOFF inside the hysteresis band
    hi = 4'd12; lo = 4'd4;
    step(4'd6);
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    wait_valid(4, got);
    chk(got, "R7", "sw XOFF sent", int'(got), 1);
    if (got) recv(pt, 1'b0, "R7");
    sent = 1;
    wait_valid(10, got);
    chk(!got, "R6", "no frame within band after sw XOFF", int'(got), 0);
    step(4'd4);
    step(4'd3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule